// File: doc/BRIEF.md
# I2C Bus Error Monitor with Recovery Handshake

This block sits beside an I2C slave shift engine and watches the synchronized SDA and SCL lines. It keeps its own count of completed bits within the current 9-slot frame (data bits followed by the acknowledge slot). A START or STOP that arrives while the engine is busy and at least one bit of the current frame has completed is a misplaced condition. That includes a condition inside a data or address byte and one inside the acknowledge slot. The block then raises a one-cycle error pulse, sets the event flag, switches the status code to the bus-error value and tells the engine to let go of both lines.

The error stays latched, and later bus activity is ignored, until a recovery command arrives. The command is a control write that clears the event flag by writing one while the stop-request bit is set. The stop-request bit may be set in that same write or in an earlier one. On recovery the block pulses an engine reset, which returns the engine to the not-addressed slave state. It also clears the stop-request bit by itself and returns the status code to the no-information value. No STOP condition is ever driven. A repeated START or a STOP at a byte boundary is treated as legal, and so is any condition while the engine is idle.

Top module: `i2c_buserr_mon`

## Requirements
- R1: After reset, status_o is 0xF8, and evt_flag_o, err_pulse_o, bus_release_o, eng_reset_o and stop_req_o are all 0.
- R2: A START (SDA falling while SCL stays high) seen while eng_idle_i is 0 and between 1 and DATA_BITS-1 bits of the frame have completed raises err_pulse_o, sets evt_flag_o and drives status_o to 0x00.
- R3: A STOP (SDA rising while SCL stays high) seen in the same position also gives a bus error, with the same outputs as in R2.
- R4: A START or STOP during the acknowledge slot (DATA_BITS bits completed, SCL high for the ninth clock) while the engine is busy is a bus error.
- R5: A repeated START after a complete frame (acknowledge clock finished, no bit of the next frame completed) is legal and gives no error.
- R6: While eng_idle_i is 1, no START or STOP in any position raises an error.
- R7: While an error is pending, bus_release_o is 1, status_o stays 0x00 and further START/STOP conditions raise no further pulse.
- R8: A control write with csr_flag_wr1_i=1 and csr_stop_i=1 while an error is pending gives a one-cycle eng_reset_o. In the same cycle it clears evt_flag_o and stop_req_o, returns status_o to 0xF8 and drops bus_release_o. After that, errors are detected again.
- R9: A flag-clear write without the stop-request bit set clears evt_flag_o but does not recover: status_o stays 0x00, bus_release_o stays 1 and eng_reset_o stays 0.
- R10: The stop-request field is write-one-to-set. Set by an earlier write, it is held, and a later flag-clear write alone then performs the recovery of R8.
- R11: A STOP at a frame boundary (no bit completed yet) while the engine is busy is legal.
- R12: err_pulse_o and eng_reset_o are each high for exactly one clock cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| eng_idle_i | input | 1 | Engine is idle (not in an address or data transfer) |
| csr_wr_i | input | 1 | Control write strobe |
| csr_flag_wr1_i | input | 1 | Write-one-to-clear of the event flag |
| csr_stop_i | input | 1 | Write-one-to-set of the stop-request bit |
| err_pulse_o | output | 1 | One-cycle bus error pulse |
| evt_flag_o | output | 1 | Event flag |
| status_o | output | 8 | Status code: 0x00 on bus error, 0xF8 otherwise |
| stop_req_o | output | 1 | Current stop-request bit |
| bus_release_o | output | 1 | Engine must release SDA and SCL |
| eng_reset_o | output | 1 | One-cycle return of the engine to not-addressed state |

## Verification
The bench builds the block with its default DATA_BITS of 8. This makes the full bit count reachable, from position 0 through the acknowledge position 8 and the wrap back to 0 after the ninth falling SCL edge. Table rows place a START or STOP after 0, 1, 3, 5, 7, 8 and 9 clocked bits, with the engine both busy and idle. This covers boundary, mid-byte and acknowledge-slot positions. Directed sequences then cover the pending state, the two ways of arming the stop-request bit, and detection after recovery.

// File: rtl/i2c_buserr_pkg.sv
// Package: shared status codes for the I2C bus error monitor.
package i2c_buserr_pkg;
    localparam logic [7:0] ST_BUS_ERROR = 8'h00;
    localparam logic [7:0] ST_NO_INFO   = 8'hF8;
endpackage

// File: rtl/i2c_cond_detect.sv
// Detects START, STOP and SCL edges from synchronized line levels.
// Assumes scl_i/sda_i are already synchronized to clk; lines idle high.
module i2c_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);
    logic scl_q, sda_q;

    // Hold previous line levels; reset to idle-high so reset never looks like an event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Decode events from the current and previous levels.
    always_comb begin
        start_o    = scl_i & scl_q & sda_q & ~sda_i;
        stop_o     = scl_i & scl_q & ~sda_q & sda_i;
        scl_rise_o = scl_i & ~scl_q;
        scl_fall_o = ~scl_i & scl_q;
    end

    a_r2_start_stop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));
endmodule

// File: rtl/i2c_frame_tracker.sv
// Counts completed bits of the current frame: 0..DATA_BITS, where DATA_BITS is
// the acknowledge slot. A falling SCL edge only counts if a rising edge came
// after the last START/STOP, so the SCL fall that follows a START is skipped.
module i2c_frame_tracker #(
    parameter int DATA_BITS = 8,
    localparam int POS_W = $clog2(DATA_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    input  logic             clear_i,
    output logic [POS_W-1:0] pos_o
);
    localparam logic [POS_W-1:0] ACK_POS = POS_W'(DATA_BITS);

    logic armed;

    // Track completed bits; conditions and recovery restart the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_o <= '0;
            armed <= 1'b0;
        end else if (start_i || stop_i || clear_i) begin
            pos_o <= '0;
            armed <= 1'b0;
        end else if (scl_rise_i) begin
            armed <= 1'b1;
        end else if (scl_fall_i && armed) begin
            armed <= 1'b0;
            pos_o <= (pos_o == ACK_POS) ? '0 : pos_o + 1'b1;
        end
    end

    a_r4_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pos_o <= ACK_POS);
    a_r5_wrap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_fall_i && armed && pos_o == ACK_POS && !start_i && !stop_i && !clear_i)
        |=> pos_o == '0);
endmodule

// File: rtl/i2c_err_ctl.sv
// Classifies START/STOP by frame position, latches the bus error and runs the
// recovery handshake (flag write-one-to-clear with stop-request set).
// Assumes pos_i comes from i2c_frame_tracker and eng_idle_i from the engine.
module i2c_err_ctl
    import i2c_buserr_pkg::*;
#(
    parameter int POS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic             eng_idle_i,
    input  logic             csr_wr_i,
    input  logic             csr_flag_wr1_i,
    input  logic             csr_stop_i,
    output logic             err_pulse_o,
    output logic             evt_flag_o,
    output logic [7:0]       status_o,
    output logic             stop_req_o,
    output logic             bus_release_o,
    output logic             eng_reset_o
);
    logic err_pend, illegal, recover;

    // Misplaced condition and recovery decode.
    always_comb begin
        illegal = (start_i | stop_i) & ~eng_idle_i & (pos_i != '0) & ~err_pend;
        recover = csr_wr_i & csr_flag_wr1_i & (csr_stop_i | stop_req_o) & err_pend;
    end

    // Error latch, pulses, event flag and stop-request bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pend    <= 1'b0;
            err_pulse_o <= 1'b0;
            eng_reset_o <= 1'b0;
            evt_flag_o  <= 1'b0;
            stop_req_o  <= 1'b0;
        end else begin
            err_pulse_o <= illegal;
            eng_reset_o <= recover;
            if (illegal)       err_pend <= 1'b1;
            else if (recover)  err_pend <= 1'b0;
            if (illegal)                              evt_flag_o <= 1'b1;
            else if (csr_wr_i && csr_flag_wr1_i)      evt_flag_o <= 1'b0;
            if (recover)                              stop_req_o <= 1'b0;
            else if (csr_wr_i && csr_stop_i)          stop_req_o <= 1'b1;
        end
    end

    // Status and line release follow the latched error.
    always_comb begin
        status_o      = err_pend ? ST_BUS_ERROR : ST_NO_INFO;
        bus_release_o = err_pend;
    end

    a_r2_error_position: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse_o |-> ($past(pos_i) != '0) && !$past(eng_idle_i));
    a_r2_pulse_sets_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse_o |-> evt_flag_o && status_o == ST_BUS_ERROR && bus_release_o);
    a_r7_no_pulse_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse_o |-> !$past(err_pend));
    a_r8_recovery_clears: assert property (@(posedge clk) disable iff (!rst_n)
        eng_reset_o |-> !stop_req_o && !evt_flag_o && status_o == ST_NO_INFO);
    a_r12_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse_o |=> !err_pulse_o);
    a_r12_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
        eng_reset_o |=> !eng_reset_o);
endmodule

// File: rtl/i2c_buserr_mon.sv
// Top: I2C bus error monitor. Watches synchronized lines, flags misplaced
// START/STOP conditions and returns the engine to not-addressed on recovery.
// Assumes the engine honours bus_release_o and eng_reset_o; no STOP is driven.
module i2c_buserr_mon #(
    parameter int DATA_BITS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       eng_idle_i,
    input  logic       csr_wr_i,
    input  logic       csr_flag_wr1_i,
    input  logic       csr_stop_i,
    output logic       err_pulse_o,
    output logic       evt_flag_o,
    output logic [7:0] status_o,
    output logic       stop_req_o,
    output logic       bus_release_o,
    output logic       eng_reset_o
);
    localparam int POS_W = $clog2(DATA_BITS + 1);

    logic             start_w, stop_w, rise_w, fall_w;
    logic [POS_W-1:0] pos_w;

    i2c_cond_detect u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .start_o    (start_w),
        .stop_o     (stop_w),
        .scl_rise_o (rise_w),
        .scl_fall_o (fall_w)
    );

    i2c_frame_tracker #(.DATA_BITS(DATA_BITS)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_w),
        .stop_i     (stop_w),
        .scl_rise_i (rise_w),
        .scl_fall_i (fall_w),
        .clear_i    (eng_reset_o),
        .pos_o      (pos_w)
    );

    i2c_err_ctl #(.POS_W(POS_W)) u_err (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_w),
        .stop_i         (stop_w),
        .pos_i          (pos_w),
        .eng_idle_i     (eng_idle_i),
        .csr_wr_i       (csr_wr_i),
        .csr_flag_wr1_i (csr_flag_wr1_i),
        .csr_stop_i     (csr_stop_i),
        .err_pulse_o    (err_pulse_o),
        .evt_flag_o     (evt_flag_o),
        .status_o       (status_o),
        .stop_req_o     (stop_req_o),
        .bus_release_o  (bus_release_o),
        .eng_reset_o    (eng_reset_o)
    );
endmodule

// File: tb/sim_i2c_buserr_mon.sv
module sim_i2c_buserr_mon;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda = 1'b1, eng_idle = 1'b1;
    logic       csr_wr = 1'b0, csr_flag = 1'b0, csr_stop = 1'b0;
    logic       err_pulse, evt_flag, stop_req, bus_rel, eng_rst;
    logic [7:0] status;

    int checks = 0, errors = 0;
    int pulse_cnt = 0, rst_cnt = 0;

    always #(CLK_P/2) clk = ~clk;

    i2c_buserr_mon u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .eng_idle_i(eng_idle),
        .csr_wr_i(csr_wr), .csr_flag_wr1_i(csr_flag), .csr_stop_i(csr_stop),
        .err_pulse_o(err_pulse), .evt_flag_o(evt_flag), .status_o(status),
        .stop_req_o(stop_req), .bus_release_o(bus_rel), .eng_reset_o(eng_rst)
    );

    // Count high cycles of both pulse outputs, sampled just after each edge.
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            pulse_cnt += int'(err_pulse);
            rst_cnt   += int'(eng_rst);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic lines(input logic c, input logic d);
        @(negedge clk);
        scl = c;
        sda = d;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; scl = 1'b1; sda = 1'b1; eng_idle = 1'b1;
        csr_wr = 1'b0; csr_flag = 1'b0; csr_stop = 1'b0;
        idle_cycles(3);
        rst_n = 1'b1;
        pulse_cnt = 0;
        rst_cnt = 0;
    endtask

    task automatic csr_write(input logic f, input logic s);
        @(negedge clk);
        csr_wr = 1'b1; csr_flag = f; csr_stop = s;
        @(negedge clk);
        csr_wr = 1'b0; csr_flag = 1'b0; csr_stop = 1'b0;
    endtask

    // START from idle bus with engine idle, then clock n full bits with given engine state.
    task automatic frame_bits(input int n, input logic idle_during);
        eng_idle = 1'b1;
        lines(1'b1, 1'b1);
        lines(1'b1, 1'b0);
        lines(1'b0, 1'b0);
        eng_idle = idle_during;
        for (int k = 0; k < n; k++) begin
            lines(1'b1, 1'b0);
            lines(1'b0, 1'b0);
        end
    endtask

    task automatic cond(input logic is_stop);
        if (is_stop) begin
            lines(1'b0, 1'b0);
            lines(1'b1, 1'b0);
            lines(1'b1, 1'b1);
        end else begin
            lines(1'b0, 1'b1);
            lines(1'b1, 1'b1);
            lines(1'b1, 1'b0);
        end
        idle_cycles(2);
    endtask

    // Row: {bits[3:0], is_stop, eng_idle, expect_error}
    localparam int NV = 11;
    localparam logic [6:0] VEC [NV] = '{
        {4'd0, 1'b0, 1'b0, 1'b0},  // R5 START at frame start
        {4'd0, 1'b1, 1'b0, 1'b0},  // R11 STOP at boundary
        {4'd3, 1'b0, 1'b0, 1'b1},  // R2 START mid-byte
        {4'd1, 1'b1, 1'b0, 1'b1},  // R3 STOP mid-byte
        {4'd7, 1'b1, 1'b0, 1'b1},  // R3 STOP last data bit
        {4'd8, 1'b0, 1'b0, 1'b1},  // R4 START in ack
        {4'd8, 1'b1, 1'b0, 1'b1},  // R4 STOP in ack
        {4'd5, 1'b0, 1'b1, 1'b0},  // R6 engine idle
        {4'd8, 1'b1, 1'b1, 1'b0},  // R6 engine idle, ack slot
        {4'd9, 1'b0, 1'b0, 1'b0},  // R5 repeated START after full frame
        {4'd9, 1'b1, 1'b0, 1'b0}   // R11 STOP after full frame
    };

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        idle_cycles(1);
        // R1 reset state
        chk("R1 status", status, 8'hF8);
        chk("R1 flag", evt_flag, 0);
        chk("R1 pulse", err_pulse, 0);
        chk("R1 release", bus_rel, 0);
        chk("R1 engine reset", eng_rst, 0);
        chk("R1 stop request", stop_req, 0);

        for (int v = 0; v < NV; v++) begin
            logic [6:0] e;
            string tag;
            e = VEC[v];
            tag = $sformatf("row %0d (R2/R3/R4/R5/R6/R11/R12)", v);
            do_reset();
            frame_bits(int'(e[6:3]), e[1]);
            cond(e[2]);
            chk({tag, " pulses"}, pulse_cnt, int'(e[0]));
            chk({tag, " flag"}, evt_flag, int'(e[0]));
            chk({tag, " status"}, status, e[0] ? 8'h00 : 8'hF8);
            chk({tag, " release"}, bus_rel, int'(e[0]));
        end

        // R7 pending error ignores further conditions
        do_reset();
        frame_bits(4, 1'b0);
        cond(1'b0);
        lines(1'b1, 1'b1);
        lines(1'b1, 1'b0);
        lines(1'b1, 1'b1);
        idle_cycles(2);
        chk("R7 no extra pulse", pulse_cnt, 1);
        chk("R7 status held", status, 8'h00);
        chk("R7 release held", bus_rel, 1);

        // R9 flag clear alone does not recover
        csr_write(1'b1, 1'b0);
        idle_cycles(1);
        chk("R9 flag cleared", evt_flag, 0);
        chk("R9 status", status, 8'h00);
        chk("R9 release", bus_rel, 1);
        chk("R9 no engine reset", rst_cnt, 0);

        // R10 stop-request set earlier, then flag clear recovers
        csr_write(1'b0, 1'b1);
        idle_cycles(1);
        chk("R10 stop request held", stop_req, 1);
        chk("R10 still pending", status, 8'h00);
        csr_write(1'b1, 1'b0);
        idle_cycles(1);
        chk("R10 engine reset", rst_cnt, 1);
        chk("R10 stop request cleared", stop_req, 0);
        chk("R10 status", status, 8'hF8);

        // R8 combined write recovers, then detection works again
        do_reset();
        frame_bits(2, 1'b0);
        cond(1'b1);
        chk("R8 error before recovery", pulse_cnt, 1);
        @(negedge clk);
        csr_wr = 1'b1; csr_flag = 1'b1; csr_stop = 1'b1;
        @(negedge clk);
        csr_wr = 1'b0; csr_flag = 1'b0; csr_stop = 1'b0;
        chk("R8 engine reset high", eng_rst, 1);
        chk("R8 flag", evt_flag, 0);
        chk("R8 stop request", stop_req, 0);
        chk("R8 status", status, 8'hF8);
        chk("R8 release", bus_rel, 0);
        idle_cycles(2);
        chk("R12 engine reset single cycle", rst_cnt, 1);
        frame_bits(6, 1'b0);
        cond(1'b0);
        chk("R8 detects again", pulse_cnt, 2);
        chk("R8 flag again", evt_flag, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule